// File: doc/BRIEF.md
# Four-Source Operand Forwarding Unit

This block decides, for the instruction held between register fetch and execute in an eight-stage integer pipeline, where each of its two ALU operands comes from. It compares the instruction's two source register numbers with the destination registers of the four older instructions further down the pipe. These four stages are numbered from youngest to oldest: execute/data-first (stage 1), data-first/data-second (stage 2), data-second/tag-check (stage 3) and tag-check/writeback (stage 4). For each operand it produces a select code and the chosen operand value.

The block is purely combinational. A result is taken from the youngest stage that writes the wanted register. If the youngest stage that writes the register is a load that is still in stage 1 or stage 2, its data is not ready yet. In that case the operand falls back to the register file, older matches are not used, and a hazard flag is raised for the stall logic outside this block. The top operand can be forwarded for every kind of consumer. The bottom operand is forwarded only when the consumer is a register-register ALU instruction.

Top module: `fwd_unit`

## Requirements
- R1: When no stage matches an operand, its select is 0, its hazard flag is 0 and its value equals the register-file input for that operand.
- R2: A register-register ALU producer (class code 0) or ALU-immediate producer (class code 1) that matches is forwarded from any stage. The select is then the stage number (1 = youngest through 4 = oldest) and the value is that stage's result.
- R3: A load producer (class code 2) that matches in stage 3 or stage 4 is forwarded, with select 3 or 4 respectively.
- R4: When the youngest matching stage holds a load in stage 1 or 2, the select is 0, the value is the register-file input and the hazard flag is 1, even if older stages also match.
- R5: Store producers (code 3), branch producers (code 4) and the unused codes 5 to 7 never match.
- R6: A stage matches only when its valid bit is 1 and its destination register is nonzero.
- R7: When several stages match, the youngest one (the lowest stage number) is selected.
- R8: The bottom operand is forwarded only when the consumer class is 0. For any other consumer class its select is 0, its hazard flag is 0 and its value is the register-file input.
- R9: The top operand is forwarded for every consumer class: 0 register-register, 1 immediate, 2 load, 3 store, 4 branch.
- R10: The two operands are resolved independently, so each can select a different stage in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| stg_valid_i | input | 4 | Valid bit per stage, bit 0 = stage 1 |
| stg_dest_i | input | 4x5 | Destination register per stage |
| stg_data_i | input | 4x32 | Result value per stage |
| stg_class_i | input | 4x3 | Producer class code per stage |
| use_class_i | input | 3 | Class code of the consuming instruction |
| rs_a_i | input | 5 | Top operand source register |
| rs_b_i | input | 5 | Bottom operand source register |
| rf_a_i | input | 32 | Top operand value from the register file |
| rf_b_i | input | 32 | Bottom operand value from the register file |
| sel_a_o | output | 3 | Top operand select (0 = register file, 1 to 4 = stage) |
| sel_b_o | output | 3 | Bottom operand select |
| opnd_a_o | output | 32 | Top operand value |
| opnd_b_o | output | 32 | Bottom operand value |
| hazard_a_o | output | 1 | Top operand waits on a load in stage 1 or 2 |
| hazard_b_o | output | 1 | Bottom operand waits on a load in stage 1 or 2 |

## Verification
Directed patterns place one matching producer in each stage in turn, which shows that the stage numbering is right and that each result reaches the output. Stacked matches across several stages test the youngest-first priority. A load placed above older ALU matches shows the difference between masking the older results and falling through to them. Store, branch, invalid and register-zero producers show that the match qualifiers are applied. The consumer class is varied with a bottom-operand match present, which shows that only the bottom operand is restricted. Several hundred random cycles then draw from a small register pool, so that multi-stage collisions are frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  parameter int NUM_SRC    = 4;
  parameter int REG_AW     = 5;
  parameter int DATA_W     = 32;
  parameter int CLS_W      = 3;
  parameter int LOAD_FIRST = 2;  // 0-based index of first stage where load data is ready
  localparam int SEL_W     = $clog2(NUM_SRC + 1);

  typedef enum logic [CLS_W-1:0] {
    CLS_RR     = 3'd0,
    CLS_IMM    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4
  } cls_e;

  function automatic logic writes_reg(input logic [CLS_W-1:0] c);
    return (c == CLS_RR) || (c == CLS_IMM) || (c == CLS_LOAD);
  endfunction
endpackage

// File: rtl/fwd_cmp.sv
module fwd_cmp
  import fwd_pkg::*;
(
  input  logic [NUM_SRC-1:0]             valid_i,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] dest_i,
  input  logic [NUM_SRC-1:0][CLS_W-1:0]  cls_i,
  input  logic [REG_AW-1:0]              rs_i,
  output logic [NUM_SRC-1:0]             hit_o,
  output logic [NUM_SRC-1:0]             early_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit;
    assign hit        = valid_i[i] && (dest_i[i] != '0) && (dest_i[i] == rs_i)
                        && writes_reg(cls_i[i]);
    assign hit_o[i]   = hit;
    if (i < LOAD_FIRST) begin : g_early
      assign early_o[i] = hit && (cls_i[i] == CLS_LOAD);
    end else begin : g_late
      assign early_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
  import fwd_pkg::*;
(
  input  logic                 en_i,
  input  logic [NUM_SRC-1:0]   hit_i,
  input  logic [NUM_SRC-1:0]   early_i,
  output logic [SEL_W-1:0]     sel_o,
  output logic                 hazard_o
);
  // scan oldest to youngest; last write wins, so the youngest hit decides
  always_comb begin
    sel_o    = '0;
    hazard_o = 1'b0;
    if (en_i) begin
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (hit_i[i]) begin
          hazard_o = early_i[i];
          sel_o    = early_i[i] ? '0 : SEL_W'(i + 1);
        end
      end
    end
  end

  always_comb begin
    p_haz_no_sel_r4: assert (!hazard_o || sel_o == '0)
      else $error("hazard with nonzero select");
    p_disabled_r8: assert (en_i || (sel_o == '0 && !hazard_o))
      else $error("disabled operand forwarded");
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
(
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0]              rf_i,
  output logic [DATA_W-1:0]              val_o
);
  always_comb begin
    val_o = rf_i;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel_i == SEL_W'(i + 1)) val_o = data_i[i];
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
(
  input  logic [NUM_SRC-1:0]             stg_valid_i,
  input  logic [NUM_SRC-1:0][REG_AW-1:0] stg_dest_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] stg_data_i,
  input  logic [NUM_SRC-1:0][CLS_W-1:0]  stg_class_i,
  input  logic [CLS_W-1:0]               use_class_i,
  input  logic [REG_AW-1:0]              rs_a_i,
  input  logic [REG_AW-1:0]              rs_b_i,
  input  logic [DATA_W-1:0]              rf_a_i,
  input  logic [DATA_W-1:0]              rf_b_i,
  output logic [SEL_W-1:0]               sel_a_o,
  output logic [SEL_W-1:0]               sel_b_o,
  output logic [DATA_W-1:0]              opnd_a_o,
  output logic [DATA_W-1:0]              opnd_b_o,
  output logic                           hazard_a_o,
  output logic                           hazard_b_o
);
  localparam int NUM_OP = 2;

  logic [NUM_OP-1:0][REG_AW-1:0] rs;
  logic [NUM_OP-1:0][DATA_W-1:0] rf;
  logic [NUM_OP-1:0][SEL_W-1:0]  sel;
  logic [NUM_OP-1:0][DATA_W-1:0] val;
  logic [NUM_OP-1:0]             haz;
  logic [NUM_OP-1:0]             en;

  assign rs = {rs_b_i, rs_a_i};
  assign rf = {rf_b_i, rf_a_i};
  assign en = {(use_class_i == CLS_RR), 1'b1};  // bottom input only for reg-reg

  for (genvar k = 0; k < NUM_OP; k++) begin : g_op
    logic [NUM_SRC-1:0] hit, early;

    fwd_cmp u_cmp (
      .valid_i (stg_valid_i),
      .dest_i  (stg_dest_i),
      .cls_i   (stg_class_i),
      .rs_i    (rs[k]),
      .hit_o   (hit),
      .early_o (early)
    );

    fwd_prio u_prio (
      .en_i     (en[k]),
      .hit_i    (hit),
      .early_i  (early),
      .sel_o    (sel[k]),
      .hazard_o (haz[k])
    );

    fwd_mux u_mux (
      .sel_i  (sel[k]),
      .data_i (stg_data_i),
      .rf_i   (rf[k]),
      .val_o  (val[k])
    );

    always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (sel[k] == SEL_W'(i + 1)) begin
          p_src_qual_r6: assert (stg_valid_i[i] && stg_dest_i[i] != '0 && stg_dest_i[i] == rs[k])
            else $error("forwarded from unqualified stage");
          p_src_writes_r5: assert (writes_reg(stg_class_i[i]))
            else $error("forwarded from non-writing producer");
          p_load_late_r3: assert (stg_class_i[i] != CLS_LOAD || i >= LOAD_FIRST)
            else $error("load forwarded too early");
          p_value_r2: assert (val[k] == stg_data_i[i])
            else $error("value does not follow select");
          for (int j = 0; j < i; j++) begin
            p_youngest_r7: assert (!(stg_valid_i[j] && stg_dest_i[j] == rs[k]
                                    && writes_reg(stg_class_i[j])))
              else $error("younger match skipped");
          end
        end
      end
    end
  end

  assign sel_a_o    = sel[0];
  assign sel_b_o    = sel[1];
  assign opnd_a_o   = val[0];
  assign opnd_b_o   = val[1];
  assign hazard_a_o = haz[0];
  assign hazard_b_o = haz[1];
endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]       v;
  logic [3:0][4:0]  d;
  logic [3:0][31:0] x;
  logic [3:0][2:0]  c;
  logic [2:0]       uc;
  logic [4:0]       rsa, rsb;
  logic [31:0]      rfa, rfb;
  logic [2:0]       sel_a, sel_b;
  logic [31:0]      oa, ob;
  logic             ha, hb;

  int checks = 0;
  int errors = 0;

  fwd_unit uut (
    .stg_valid_i(v), .stg_dest_i(d), .stg_data_i(x), .stg_class_i(c),
    .use_class_i(uc), .rs_a_i(rsa), .rs_b_i(rsb), .rf_a_i(rfa), .rf_b_i(rfb),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(oa), .opnd_b_o(ob),
    .hazard_a_o(ha), .hazard_b_o(hb)
  );

  // behavioural reference: walk stages youngest first
  function automatic void ref_op(input int k, output int sel, output bit haz,
                                 output logic [31:0] val, output string tag);
    logic [4:0] r;
    r   = (k == 1) ? rsb : rsa;
    val = (k == 1) ? rfb : rfa;
    sel = 0; haz = 1'b0; tag = "R1";
    if (k == 1 && uc != 3'd0) begin tag = "R8"; return; end
    for (int i = 0; i < 4; i++) begin
      if (v[i] && d[i] != 0 && d[i] == r && c[i] <= 3'd2) begin
        if (c[i] == 3'd2 && i < 2) begin haz = 1'b1; tag = "R4"; end
        else begin sel = i + 1; val = x[i]; tag = (c[i] == 3'd2) ? "R3" : "R2"; end
        return;
      end
    end
  endfunction

  task automatic compare(input string lbl);
    int es; bit eh; logic [31:0] ev; string tag;
    for (int k = 0; k < 2; k++) begin
      int as_; bit ah; logic [31:0] av;
      ref_op(k, es, eh, ev, tag);
      as_ = (k == 0) ? int'(sel_a) : int'(sel_b);
      ah  = (k == 0) ? ha : hb;
      av  = (k == 0) ? oa : ob;
      checks++;
      if (as_ != es || ah != eh || av !== ev) begin
        errors++;
        $display("FAIL %s %s op%0d: sel=%0d haz=%0d val=%h expected sel=%0d haz=%0d val=%h",
                 tag, lbl, k, as_, ah, av, es, eh, ev);
      end
    end
  endtask

  task automatic clear();
    v = '0; d = '0; c = '0; uc = 3'd0; rsa = 5'd0; rsb = 5'd0;
    rfa = 32'hAAAA_0000; rfb = 32'hBBBB_0000;
    for (int i = 0; i < 4; i++) x[i] = 32'h1000_0000 + i;
  endtask

  task automatic put(input int i, input logic [4:0] dst, input logic [2:0] cls);
    v[i] = 1'b1; d[i] = dst; c[i] = cls;
  endtask

  task automatic step(input string lbl);
    @(negedge clk);
    compare(lbl);
    @(posedge clk);
  endtask

  initial begin
    clear();
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    step("R1 idle");                                     // R1
    for (int s = 0; s < 4; s++) begin                    // R2 each stage, reg-reg and imm
      clear(); rsa = 5'd7; rsb = 5'd7; put(s, 5'd7, 3'd0); step("R2 rr");
      clear(); rsa = 5'd9; put(s, 5'd9, 3'd1); step("R2 imm");
    end
    for (int s = 0; s < 4; s++) begin                    // R3 late load, R4 early load
      clear(); rsa = 5'd4; rsb = 5'd4; put(s, 5'd4, 3'd2); step("R3/R4 load");
    end
    clear(); rsa = 5'd5; put(0, 5'd5, 3'd2); put(2, 5'd5, 3'd0); put(3, 5'd5, 3'd1);
    step("R4 mask");
    clear(); rsa = 5'd5; put(1, 5'd5, 3'd2); put(3, 5'd5, 3'd0); step("R4 mask2");
    for (int cc = 3; cc < 8; cc++) begin                 // R5 non-writers
      clear(); rsa = 5'd3; rsb = 5'd3; put(0, 5'd3, 3'(cc)); step("R5 nonwrite");
    end
    clear(); rsa = 5'd3; put(0, 5'd3, 3'd0); v[0] = 1'b0; step("R6 invalid");
    clear(); rsa = 5'd0; rsb = 5'd0; put(0, 5'd0, 3'd0); put(2, 5'd0, 3'd1);
    step("R6 zero");
    clear(); rsa = 5'd6; for (int i = 0; i < 4; i++) put(i, 5'd6, 3'd0); step("R7 all");
    clear(); rsa = 5'd6; put(1, 5'd6, 3'd1); put(2, 5'd6, 3'd2); put(3, 5'd6, 3'd0);
    step("R7 mid");
    for (int u = 1; u < 5; u++) begin                    // R8 bottom gated, R9 top always
      clear(); uc = 3'(u); rsa = 5'd8; rsb = 5'd8; put(1, 5'd8, 3'd0); step("R8/R9 class");
    end
    clear(); rsa = 5'd2; rsb = 5'd11; put(0, 5'd11, 3'd0); put(3, 5'd2, 3'd2);
    step("R10 split");
    for (int n = 0; n < 400; n++) begin                  // R2..R10 random mix
      v = 4'($urandom); uc = 3'($urandom_range(0, 4));
      rsa = 5'($urandom_range(0, 3)); rsb = 5'($urandom_range(0, 3));
      rfa = $urandom; rfb = $urandom;
      for (int i = 0; i < 4; i++) begin
        d[i] = 5'($urandom_range(0, 3)); c[i] = 3'($urandom); x[i] = $urandom;
      end
      step("random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired: got hang, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule